// File: doc/BRIEF.md
# Debug Mode Console with Serial State Reporter

This block gives an operator a one-button window into a receive pipeline. It runs on a single system clock. A raw push-button input is synchronised, debounced and reduced to one press pulse, and each pulse flips a debug-mode flag. With the flag clear, a 4-bit indicator output carries the running frame count. With the flag set, the same output steps through the low nibbles of four stored management-register values. It holds each nibble for a fixed dwell time and wraps after the fourth.

While the flag is set, a serial transmitter keeps reporting the current code of an external sequencer. Each report is three bytes: the code as one ASCII hex character, a line feed, and a carriage return. Reports run back to back for as long as debug mode stays on. A frame-activity input is passed to an indicator output in both modes.

The default timing is a 100 MHz clock, a 20 ms debounce window, a 2 s dwell per register, and 115200 baud with 8N1 framing. All four are parameters, so a test can shorten them.

Top module: `debug_console`

## Requirements
- R1: After reset, debug_mode is 0, uart_txd is 1 (idle), and led equals frame_count.
- R2: A level change on btn_raw that lasts fewer than DEBOUNCE cycles (CLK_HZ/1000*DEBOUNCE_MS) after the two-stage synchroniser does not change debug_mode. Repeated bouncing shorter than that window is ignored.
- R3: A press held for at least the debounce window toggles debug_mode exactly once, however long it is held. A release never toggles it.
- R4: While debug_mode is 0, led equals frame_count.
- R5: On entry to debug mode the selected register index is 0, so led shows reg_nibbles[3:0].
- R6: In debug mode the index advances by one every DWELL cycles (CLK_HZ/1000*DWELL_MS) through 0,1,2,3 and then wraps to 0. led shows reg_nibbles[4*i+3:4*i] for index i.
- R7: activity_led equals frame_activity in both modes.
- R8: Every serial byte is one 0 start bit, eight data bits sent LSB first, and one 1 stop bit. Each bit lasts round(CLK_HZ/BAUD) cycles, and the line idles at 1.
- R9: A report is the ASCII hex digit of seq_state taken when the report starts ('0'-'9' = 0x30-0x39, 'A'-'F' = 0x41-0x46), then 0x0A, then 0x0D.
- R10: A report starts only while debug_mode is 1. A report already in progress when debug mode is cleared still sends all three bytes, and then the line stays idle.
- R11: A byte is loaded only when the previous byte has fully finished. Within a report, and between reports while debug mode stays on, start bits are exactly 10*bit_cycles+1 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_raw | input | 1 | Raw push-button level, asynchronous, active high |
| frame_count | input | LED_W | Frame count shown in normal mode |
| frame_activity | input | 1 | Frame activity flag |
| seq_state | input | 4 | Sequencer state code to report |
| reg_nibbles | input | NUM_REGS*LED_W | Low nibble of each stored register, index 0 in the least significant bits |
| led | output | LED_W | Indicator value (frame count or register nibble) |
| activity_led | output | 1 | Frame activity indicator |
| debug_mode | output | 1 | Current debug-mode flag |
| uart_txd | output | 1 | Serial transmit line |

## Verification
The button is driven with a short single glitch, a burst of bounces shorter than the window, and a long hold followed by a release. These separate three failure modes: a debouncer that is too eager, one that double-toggles while the button is held, and one that toggles on release. The register nibbles are all different, and debug mode is held across more than one full wrap, so a wrong dwell count, a wrong wrap point, or a missing index restart on re-entry each shows up as a wrong nibble in a specific cycle. Two different state codes are used, one a letter and one a digit, to cover both halves of the ASCII mapping. Debug mode is turned off in the middle of a report, which shows whether the report is finished and whether the line then stays quiet.

// File: rtl/dbc_pkg.sv
package dbc_pkg;

    localparam int CODE_W     = 4;
    localparam int FRAME_BITS = 10;

    localparam logic [7:0] ASCII_LF = 8'h0A;
    localparam logic [7:0] ASCII_CR = 8'h0D;

    typedef enum logic [1:0] {
        SLOT_DIGIT = 2'd0,
        SLOT_LF    = 2'd1,
        SLOT_CR    = 2'd2
    } rpt_slot_t;

    typedef struct packed {
        logic       load;
        logic [7:0] data;
    } tx_req_t;

    function automatic logic [7:0] hex_ascii(input logic [CODE_W-1:0] code);
        logic [7:0] wide;
        wide = {4'h0, code};
        return (code < 4'd10) ? (8'h30 + wide) : (8'h37 + wide);
    endfunction

    function automatic int round_div(input int num, input int den);
        return (num + den / 2) / den;
    endfunction

endpackage

// File: rtl/dbc_button.sv
module dbc_button #(
    parameter int DB_CYC = 2_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic btn_raw,
    output logic sync_o,
    output logic level_o,
    output logic press_o
);
    localparam int CW = $clog2(DB_CYC + 1);

    logic          meta_q;
    logic          sync_q;
    logic          level_q;
    logic          press_q;
    logic [CW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q  <= 1'b0;
            sync_q  <= 1'b0;
            level_q <= 1'b0;
            press_q <= 1'b0;
            run_q   <= '0;
        end else begin
            meta_q  <= btn_raw;
            sync_q  <= meta_q;
            press_q <= 1'b0;
            if (sync_q != level_q) begin
                if (run_q == CW'(DB_CYC - 1)) begin
                    level_q <= sync_q;
                    run_q   <= '0;
                    press_q <= sync_q;
                end else begin
                    run_q <= run_q + 1'b1;
                end
            end else begin
                run_q <= '0;
            end
        end
    end

    assign sync_o  = sync_q;
    assign level_o = level_q;
    assign press_o = press_q;

endmodule

// File: rtl/dbc_dwell.sv
module dbc_dwell #(
    parameter int DWELL_CYC = 200_000_000,
    parameter int NUM_SEL   = 4,
    parameter int IDX_W     = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    output logic [IDX_W-1:0] idx_o
);
    localparam int TW = $clog2(DWELL_CYC + 1);

    logic [TW-1:0]    tick_q;
    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            tick_q <= '0;
            idx_q  <= '0;
        end else if (tick_q == TW'(DWELL_CYC - 1)) begin
            tick_q <= '0;
            idx_q  <= (idx_q == IDX_W'(NUM_SEL - 1)) ? '0 : idx_q + 1'b1;
        end else begin
            tick_q <= tick_q + 1'b1;
        end
    end

    assign idx_o = idx_q;

endmodule

// File: rtl/dbc_uart_tx.sv
module dbc_uart_tx
    import dbc_pkg::*;
#(
    parameter int BIT_CYC = 868
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [7:0] data,
    output logic       busy,
    output logic       txd
);
    localparam int TW = $clog2(BIT_CYC + 1);

    logic [FRAME_BITS-1:0] shift_q;
    logic [TW-1:0]         tick_q;
    logic [3:0]            bitn_q;
    logic                  busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q <= '1;
            tick_q  <= '0;
            bitn_q  <= '0;
            busy_q  <= 1'b0;
        end else if (load && !busy_q) begin
            shift_q <= {1'b1, data, 1'b0};
            tick_q  <= '0;
            bitn_q  <= '0;
            busy_q  <= 1'b1;
        end else if (busy_q) begin
            if (tick_q == TW'(BIT_CYC - 1)) begin
                tick_q  <= '0;
                shift_q <= {1'b1, shift_q[FRAME_BITS-1:1]};
                if (bitn_q == 4'(FRAME_BITS - 1)) begin
                    busy_q <= 1'b0;
                end else begin
                    bitn_q <= bitn_q + 1'b1;
                end
            end else begin
                tick_q <= tick_q + 1'b1;
            end
        end
    end

    assign busy = busy_q;
    assign txd  = shift_q[0];

endmodule

// File: rtl/dbc_reporter.sv
module dbc_reporter
    import dbc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mode,
    input  logic [CODE_W-1:0] code,
    input  logic              tx_busy,
    output tx_req_t           req,
    output logic              report_start
);
    rpt_slot_t slot_q;

    always_comb begin
        req.load = !tx_busy && ((slot_q != SLOT_DIGIT) || mode);
        unique case (slot_q)
            SLOT_LF: req.data = ASCII_LF;
            SLOT_CR: req.data = ASCII_CR;
            default: req.data = hex_ascii(code);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= SLOT_DIGIT;
        end else if (req.load) begin
            unique case (slot_q)
                SLOT_DIGIT: slot_q <= SLOT_LF;
                SLOT_LF:    slot_q <= SLOT_CR;
                default:    slot_q <= SLOT_DIGIT;
            endcase
        end
    end

    assign report_start = req.load && (slot_q == SLOT_DIGIT);

endmodule

// File: rtl/debug_console.sv
module debug_console
    import dbc_pkg::*;
#(
    parameter int CLK_HZ      = 100_000_000,
    parameter int BAUD        = 115_200,
    parameter int DEBOUNCE_MS = 20,
    parameter int DWELL_MS    = 2000,
    parameter int NUM_REGS    = 4,
    parameter int LED_W       = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      btn_raw,
    input  logic [LED_W-1:0]          frame_count,
    input  logic                      frame_activity,
    input  logic [CODE_W-1:0]         seq_state,
    input  logic [NUM_REGS*LED_W-1:0] reg_nibbles,
    output logic [LED_W-1:0]          led,
    output logic                      activity_led,
    output logic                      debug_mode,
    output logic                      uart_txd
);
    localparam int MS_CYC    = CLK_HZ / 1000;
    localparam int DB_CYC    = MS_CYC * DEBOUNCE_MS;
    localparam int DWELL_CYC = MS_CYC * DWELL_MS;
    localparam int BIT_CYC   = round_div(CLK_HZ, BAUD);
    localparam int IDX_W     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic             btn_sync;
    logic             db_level;
    logic             press;
    logic             mode_q;
    logic [IDX_W-1:0] sel_idx;
    tx_req_t          tx_req;
    logic             tx_load;
    logic             tx_busy;
    logic             report_start;
    logic [LED_W-1:0] nib [NUM_REGS];

    dbc_button #(.DB_CYC(DB_CYC)) u_btn (
        .clk     (clk),
        .rst     (rst),
        .btn_raw (btn_raw),
        .sync_o  (btn_sync),
        .level_o (db_level),
        .press_o (press)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= 1'b0;
        end else if (press) begin
            mode_q <= ~mode_q;
        end
    end

    dbc_dwell #(
        .DWELL_CYC (DWELL_CYC),
        .NUM_SEL   (NUM_REGS),
        .IDX_W     (IDX_W)
    ) u_dwell (
        .clk     (clk),
        .rst     (rst),
        .restart (press | ~mode_q),
        .idx_o   (sel_idx)
    );

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_nib
        assign nib[i] = reg_nibbles[i*LED_W +: LED_W];
    end

    assign led          = mode_q ? nib[sel_idx] : frame_count;
    assign activity_led = frame_activity;
    assign debug_mode   = mode_q;

    dbc_reporter u_rpt (
        .clk          (clk),
        .rst          (rst),
        .mode         (mode_q),
        .code         (seq_state),
        .tx_busy      (tx_busy),
        .req          (tx_req),
        .report_start (report_start)
    );

    assign tx_load = tx_req.load;

    dbc_uart_tx #(.BIT_CYC(BIT_CYC)) u_tx (
        .clk  (clk),
        .rst  (rst),
        .load (tx_load),
        .data (tx_req.data),
        .busy (tx_busy),
        .txd  (uart_txd)
    );

endmodule

// File: rtl/debug_console_chk.sv
module debug_console_chk #(
    parameter int IDX_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             btn_sync,
    input logic             db_level,
    input logic             press,
    input logic             debug_mode,
    input logic [IDX_W-1:0] sel_idx,
    input logic             uart_txd,
    input logic             tx_busy,
    input logic             tx_load,
    input logic             report_start
);
    assert_level_follows_sync_R2: assert property (@(posedge clk) disable iff (rst)
        (db_level != $past(db_level)) |-> (db_level == $past(btn_sync)));

    assert_press_single_R3: assert property (@(posedge clk) disable iff (rst)
        press |=> !press);

    assert_mode_needs_press_R3: assert property (@(posedge clk) disable iff (rst)
        (debug_mode != $past(debug_mode)) |-> $past(press));

    assert_entry_index_zero_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(debug_mode) |-> (sel_idx == '0));

    assert_index_steps_R6: assert property (@(posedge clk) disable iff (rst)
        (sel_idx != $past(sel_idx)) |->
            ((sel_idx == IDX_W'($past(sel_idx) + 1'b1)) || (sel_idx == '0)));

    assert_idle_line_high_R8: assert property (@(posedge clk) disable iff (rst)
        !tx_busy |-> uart_txd);

    assert_report_gated_R10: assert property (@(posedge clk) disable iff (rst)
        report_start |-> debug_mode);

    assert_load_when_free_R11: assert property (@(posedge clk) disable iff (rst)
        tx_load |-> !tx_busy);

endmodule

bind debug_console debug_console_chk #(.IDX_W((NUM_REGS > 1) ? $clog2(NUM_REGS) : 1)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .btn_sync     (btn_sync),
    .db_level     (db_level),
    .press        (press),
    .debug_mode   (debug_mode),
    .sel_idx      (sel_idx),
    .uart_txd     (uart_txd),
    .tx_busy      (tx_busy),
    .tx_load      (tx_load),
    .report_start (report_start)
);

// File: tb/debug_console_test.sv
module debug_console_test;
    localparam int CLK_HZ  = 100_000;
    localparam int BAUD    = 10_000;
    localparam int DB_MS   = 1;
    localparam int DW_MS   = 3;
    localparam int DB_CYC  = CLK_HZ / 1000 * DB_MS;
    localparam int DW_CYC  = CLK_HZ / 1000 * DW_MS;
    localparam int BIT_CYC = (CLK_HZ + BAUD / 2) / BAUD;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst = 1'b1;
    logic        btn = 1'b0;
    logic        act = 1'b0;
    logic [3:0]  fcnt = 4'h0;
    logic [3:0]  sstate = 4'h0;
    logic [15:0] regs = 16'hC752;
    logic [3:0]  led;
    logic        activity_led;
    logic        debug_mode;
    logic        uart_txd;

    debug_console #(
        .CLK_HZ(CLK_HZ), .BAUD(BAUD), .DEBOUNCE_MS(DB_MS), .DWELL_MS(DW_MS),
        .NUM_REGS(4), .LED_W(4)
    ) uut (
        .clk(clk), .rst(rst), .btn_raw(btn), .frame_count(fcnt),
        .frame_activity(act), .seq_state(sstate), .reg_nibbles(regs),
        .led(led), .activity_led(activity_led), .debug_mode(debug_mode),
        .uart_txd(uart_txd)
    );

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    task automatic check(input bit ok, input string tag, input longint actv, input longint expv);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, actv, expv);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #2;
        end
    endtask

    function automatic int exp_hex(input int n);
        return (n < 10) ? (48 + n) : (65 + n - 10);
    endfunction

    // behavioural reference of button, mode and dwell index
    int m_s1 = 0, m_s2 = 0, m_stable = 0, m_cnt = 0, m_press = 0;
    int m_mode = 0, m_mode_prev = 0, m_tick = 0, m_idx = 0;

    always @(posedge clk) begin
        int n_press;
        m_mode_prev = m_mode;
        if (rst) begin
            m_s1 = 0; m_s2 = 0; m_stable = 0; m_cnt = 0; m_press = 0;
            m_mode = 0; m_tick = 0; m_idx = 0;
        end else begin
            if (m_press != 0 || m_mode == 0) begin
                m_tick = 0;
                m_idx  = 0;
            end else if (m_tick == DW_CYC - 1) begin
                m_tick = 0;
                m_idx  = (m_idx + 1) % 4;
            end else begin
                m_tick++;
            end
            if (m_press != 0) m_mode = 1 - m_mode;
            n_press = 0;
            if (m_s2 != m_stable) begin
                if (m_cnt == DB_CYC - 1) begin
                    m_stable = m_s2;
                    m_cnt    = 0;
                    n_press  = m_s2;
                end else begin
                    m_cnt++;
                end
            end else begin
                m_cnt = 0;
            end
            m_press = n_press;
            m_s2 = m_s1;
            m_s1 = int'(btn);
        end
    end

    // per-clock comparison
    always @(negedge clk) begin
        if (!rst) begin
            int exp_led;
            exp_led = (m_mode != 0) ? int'(regs[m_idx*4 +: 4]) : int'(fcnt);
            check(int'(debug_mode) == m_mode, "R3 debug_mode", debug_mode, m_mode);
            if (m_mode != 0)
                check(int'(led) == exp_led, "R6 led register nibble", led, exp_led);
            else
                check(int'(led) == exp_led, "R4 led frame count", led, exp_led);
            check(activity_led == act, "R7 activity_led", activity_led, act);
        end
    end

    // serial decoder
    int cyc = 0, last_start = -100000, dec_busy = 0, dec_ph = 0, dec_byte = 0;
    int rpt_pos = 0, n_bytes = 0, n_reports = 0;

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (dec_busy == 0) begin
                if (uart_txd == 1'b0) begin
                    dec_busy = 1;
                    dec_ph   = 0;
                    dec_byte = 0;
                    if (rpt_pos == 0)
                        check(m_mode_prev == 1, "R10 report start needs debug mode", m_mode_prev, 1);
                    else
                        check(cyc - last_start == 10 * BIT_CYC + 1, "R11 byte spacing",
                              cyc - last_start, 10 * BIT_CYC + 1);
                    last_start = cyc;
                end
            end else begin
                dec_ph++;
                if (dec_ph >= BIT_CYC / 2 && (dec_ph - BIT_CYC / 2) % BIT_CYC == 0) begin
                    int k;
                    k = (dec_ph - BIT_CYC / 2) / BIT_CYC;
                    if (k == 0) begin
                        check(uart_txd == 1'b0, "R8 start bit", uart_txd, 0);
                    end else if (k <= 8) begin
                        if (uart_txd) dec_byte = dec_byte | (1 << (k - 1));
                    end else begin
                        int expb;
                        check(uart_txd == 1'b1, "R8 stop bit", uart_txd, 1);
                        expb = (rpt_pos == 0) ? exp_hex(int'(sstate)) : ((rpt_pos == 1) ? 8'h0A : 8'h0D);
                        check(dec_byte == expb, "R9 report byte", dec_byte, expb);
                        n_bytes++;
                        rpt_pos = (rpt_pos + 1) % 3;
                        if (rpt_pos == 0) n_reports++;
                        dec_busy = 0;
                    end
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        vectors++;
        errors++;
        $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int bytes_mark;
        bit seen;
        step(5);
        rst = 1'b0;
        @(negedge clk);
        check(debug_mode == 1'b0, "R1 reset debug_mode", debug_mode, 0);
        check(uart_txd == 1'b1, "R1 reset uart_txd", uart_txd, 1);
        check(led == fcnt, "R1 reset led", led, fcnt);
        step(1);

        // normal mode display with changing counts and activity
        for (int i = 0; i < 16; i++) begin
            fcnt = 4'(i * 7);
            act  = i[0];
            step(3);
        end

        // single short glitch
        btn = 1'b1; step(DB_CYC / 3);
        btn = 1'b0; step(200);
        @(negedge clk);
        check(debug_mode == 1'b0, "R2 glitch ignored", debug_mode, 0);

        // bouncing shorter than the window
        for (int i = 0; i < 6; i++) begin
            btn = ~btn;
            step(DB_CYC / 5);
        end
        btn = 1'b0; step(200);
        @(negedge clk);
        check(debug_mode == 1'b0, "R2 bounce ignored", debug_mode, 0);
        check(n_bytes == 0, "R10 silent in normal mode", n_bytes, 0);

        // long press enters debug mode
        sstate = 4'hB;
        btn = 1'b1;
        seen = 0;
        for (int i = 0; i < 4 * DB_CYC; i++) begin
            step(1);
            @(negedge clk);
            if (debug_mode && !seen) begin
                seen = 1;
                check(led == regs[3:0], "R5 entry index 0", led, regs[3:0]);
            end
        end
        check(debug_mode == 1'b1, "R3 held press toggles once", debug_mode, 1);
        btn = 1'b0; step(3 * DB_CYC);
        @(negedge clk);
        check(debug_mode == 1'b1, "R3 release does not toggle", debug_mode, 1);

        fcnt = 4'h9; act = 1'b1;
        step(5 * DW_CYC);

        // leave debug mode mid report
        btn = 1'b1; step(DB_CYC + 50);
        btn = 1'b0; step(DB_CYC + 50);
        @(negedge clk);
        check(debug_mode == 1'b0, "R3 second press toggles off", debug_mode, 0);
        step(4 * 10 * BIT_CYC);
        bytes_mark = n_bytes;
        check(rpt_pos == 0, "R10 report completes after exit", rpt_pos, 0);
        step(4 * 10 * BIT_CYC);
        check(n_bytes == bytes_mark, "R10 line quiet after exit", n_bytes, bytes_mark);

        // re-enter with a digit code
        sstate = 4'h3;
        btn = 1'b1;
        seen = 0;
        for (int i = 0; i < DB_CYC + 50; i++) begin
            step(1);
            @(negedge clk);
            if (debug_mode && !seen) begin
                seen = 1;
                check(led == regs[3:0], "R5 re-entry index 0", led, regs[3:0]);
            end
        end
        btn = 1'b0;
        step(3 * DW_CYC);
        btn = 1'b1; step(DB_CYC + 50);
        btn = 1'b0; step(8 * 10 * BIT_CYC);

        check(n_reports >= 4, "R9 reports received", n_reports, 4);
        finish_run();
    end

endmodule